// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt events and steers each one to one of two processor request lines. Every channel has a 3-bit priority. That priority also sets the channel's class. Levels 0 and 1 make the channel a fast-class source. Levels 2 to 7 make it a normal-class source. An event always latches a pending bit in its class's status vector, whatever the mask says. A single per-channel enable bit decides whether that pending bit may drive a request line, and it does so for either class.

For each class, a prioritizer finds the most urgent channel that is both pending and enabled. A lower priority number is more urgent, and on a tie the lower channel number wins. From that channel the block forms a branch entry address relative to a programmable base. Software reaches the configuration, the status and the entry values through a word-indexed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: While reset is held low and after it is released, both request lines are high (inactive) and both entry outputs read 0. All status and enable words read 0, and every priority field reads 7.
- R2: An event on a channel with priority 0 or 1 sets only its bit in the fast status. An event on a channel with priority 2 to 7 sets only its bit in the normal status. Fast status is at words 1 (channels 0-31) and 2 (channels 32-63). Normal status is at words 3 and 4. Within a word, channel c sits at bit c mod 32.
- R3: A status bit is set by its event even when the channel's enable bit is 0. In that case the request line stays high.
- R4: Enable bits are at words 5 (channels 0-31) and 6 (channels 32-63), with channel c at bit c mod 32. A request line goes low exactly when some channel of its class is both pending and enabled. The same enable bit gates a channel in either class.
- R5: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If the channel's event input is high in the same cycle as the clear, the bit stays set.
- R6: Within each class, the pending and enabled channel with the smallest priority value is chosen. Among equal values, the lowest channel number is chosen.
- R7: The entry output of a class equals base + (chosen channel + 1) * 4. When no channel of the class is pending and enabled, it equals base. The fast entry reads back at word 7 and the normal entry at word 8.
- R8: The request lines and the entry outputs are registered. They reflect a change in status, enable, priority or base one clock edge after that change takes effect.
- R9: The base is a 32-bit word at word 0. Priorities are at words 16 to 23. Word 16 + c/8 holds channel c in bits [4*(c mod 8)+2 : 4*(c mod 8)]. The fourth bit of each nibble reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 64 | Level-sensitive event inputs, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fast_req_n | output | 1 | Fast-class request line, active low |
| norm_req_n | output | 1 | Normal-class request line, active low |
| fast_entry | output | 32 | Entry address of the winning fast-class channel |
| norm_entry | output | 32 | Entry address of the winning normal-class channel |

## Verification
On every cycle, the assertions check the following:
- the class-correct capture of each event into status, including masked channels;
- that a status bit never rises without an event of its class;
- that each request line follows the pending-and-enabled set one edge later;
- that an empty class presents the base.

The choice of the winning channel and its entry value, the write-one-to-clear behaviour with a held input, and the register layout can be shown only by the bench's scenarios. These scenarios cover priority ties, re-prioritisation and masking a current winner, and their results are compared against a model in the bench.

// File: rtl/itl_pkg.sv
// Package: shared constants and helpers of the two-class interrupt controller.
// Assumes: priority fields are PRIO_W bits wide; values up to FAST_TOP select
// the fast class.
package itl_pkg;
    localparam int PRIO_W   = 3;
    localparam int FAST_TOP = 1;
    localparam int NIB_W    = 4;   // register field stride of one priority
    localparam int PER_WORD = 8;   // priority fields per register word

    // Returns 1 when the priority level places a channel in the fast class.
    function automatic logic is_fast(input logic [PRIO_W-1:0] lvl);
        return lvl <= PRIO_W'(FAST_TOP);
    endfunction
endpackage

// File: rtl/itl_regs.sv
// Module: configuration registers and read multiplexer.
// Holds the entry base, the enable mask and the per-channel priorities. It
// decodes write-one-to-clear strobes for both status vectors and muxes all
// readable words onto rdata.
// Assumes: NUM_CH is a multiple of 32; the word map fits in AW bits.
module itl_regs
    import itl_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int AW     = 5,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic [NUM_CH-1:0]        fst,
    input  logic [NUM_CH-1:0]        nst,
    input  logic [DW-1:0]            fentry,
    input  logic [DW-1:0]            nentry,
    output logic [DW-1:0]            rdata,
    output logic [DW-1:0]            base,
    output logic [NUM_CH-1:0]        en,
    output logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic [NUM_CH-1:0]        fast_cls,
    output logic [NUM_CH-1:0]        clr_fast,
    output logic [NUM_CH-1:0]        clr_norm
);
    localparam int SW        = NUM_CH / 32;
    localparam int PW        = NUM_CH / PER_WORD;
    localparam int W_BASE    = 0;
    localparam int W_FST     = 1;
    localparam int W_NST     = W_FST + SW;
    localparam int W_EN      = W_NST + SW;
    localparam int W_FENT    = W_EN + SW;
    localparam int W_NENT    = W_FENT + 1;
    localparam int W_PRIO    = 16;

    logic [PRIO_W-1:0] prio_q [NUM_CH];

    // Entry base register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             base <= '0;
        else if (wr && addr == AW'(W_BASE))     base <= wdata;
    end

    genvar w, c;
    generate
        for (w = 0; w < SW; w++) begin : g_word
            // Enable mask word w.
            always_ff @(posedge clk) begin
                if (!rst_n)                              en[w*32 +: 32] <= '0;
                else if (wr && addr == AW'(W_EN + w))    en[w*32 +: 32] <= wdata[31:0];
            end
            assign clr_fast[w*32 +: 32] = (wr && addr == AW'(W_FST + w)) ? wdata[31:0] : '0;
            assign clr_norm[w*32 +: 32] = (wr && addr == AW'(W_NST + w)) ? wdata[31:0] : '0;
        end
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Priority field of channel c; resets to the least urgent level.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_q[c] <= '1;
                else if (wr && addr == AW'(W_PRIO + c / PER_WORD))
                    prio_q[c] <= wdata[NIB_W*(c % PER_WORD) +: PRIO_W];
            end
            assign prio_flat[c*PRIO_W +: PRIO_W] = prio_q[c];
            assign fast_cls[c] = is_fast(prio_q[c]);
        end
    endgenerate

    // Read multiplexer over every mapped word.
    always_comb begin
        rdata = '0;
        if (addr == AW'(W_BASE)) rdata = base;
        if (addr == AW'(W_FENT)) rdata = fentry;
        if (addr == AW'(W_NENT)) rdata = nentry;
        for (int i = 0; i < SW; i++) begin
            if (addr == AW'(W_FST + i)) rdata[31:0] = fst[i*32 +: 32];
            if (addr == AW'(W_NST + i)) rdata[31:0] = nst[i*32 +: 32];
            if (addr == AW'(W_EN + i))  rdata[31:0] = en[i*32 +: 32];
        end
        for (int p = 0; p < PW; p++) begin
            if (addr == AW'(W_PRIO + p)) begin
                for (int k = 0; k < PER_WORD; k++)
                    rdata[NIB_W*k +: PRIO_W] = prio_q[p*PER_WORD + k];
            end
        end
    end
endmodule

// File: rtl/itl_status.sv
// Module: pending status capture for both classes.
// Each cycle, an asserted event sets the bit of its current class. Clear
// strobes drop bits, and the set wins over a clear in the same cycle. The
// enable mask plays no part here.
// Assumes: events are level signals already synchronous to clk.
module itl_status #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic [NUM_CH-1:0] fast_cls,
    input  logic [NUM_CH-1:0] clr_fast,
    input  logic [NUM_CH-1:0] clr_norm,
    output logic [NUM_CH-1:0] fst,
    output logic [NUM_CH-1:0] nst
);
    // Sticky status update with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst <= '0;
            nst <= '0;
        end else begin
            fst <= (fst & ~clr_fast) | (evt & fast_cls);
            nst <= (nst & ~clr_norm) | (evt & ~fast_cls);
        end
    end
endmodule

// File: rtl/itl_pick.sv
// Module: combinational prioritizer for one class.
// Returns the requesting channel with the smallest priority value. On a tie
// it returns the lowest channel index.
// Assumes: req already combines pending and enable.
module itl_pick
    import itl_pkg::*;
#(
    parameter int NUM_CH = 64,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);
    logic [PRIO_W-1:0] best;

    // Ascending scan; only a strictly smaller level displaces the holder.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req[c] && (!hit || prio_flat[c*PRIO_W +: PRIO_W] < best)) begin
                hit  = 1'b1;
                idx  = IDX_W'(c);
                best = prio_flat[c*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_two_level_ctrl.sv
// Module: top of the two-class prioritized interrupt controller.
// Joins the register file, status capture and one prioritizer per class.
// Registers the active-low request line and the entry address of each class.
// Assumes: synchronous active-low reset; class 0 is fast, class 1 is normal.
module irq_two_level_ctrl
    import itl_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int AW     = 5,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_in,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              fast_req_n,
    output logic              norm_req_n,
    output logic [DW-1:0]     fast_entry,
    output logic [DW-1:0]     norm_entry
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [DW-1:0]            base_q;
    logic [NUM_CH-1:0]        en_q, fast_cls, clr_fast, clr_norm, fst_q, nst_q;
    logic [NUM_CH*PRIO_W-1:0] prio_flat;

    itl_regs #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .fst(fst_q), .nst(nst_q), .fentry(fast_entry), .nentry(norm_entry),
        .rdata(reg_rdata), .base(base_q), .en(en_q), .prio_flat(prio_flat),
        .fast_cls(fast_cls), .clr_fast(clr_fast), .clr_norm(clr_norm)
    );

    itl_status #(.NUM_CH(NUM_CH)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .fast_cls(fast_cls),
        .clr_fast(clr_fast), .clr_norm(clr_norm), .fst(fst_q), .nst(nst_q)
    );

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_cls
            logic [NUM_CH-1:0] req;
            logic              hit;
            logic [IDX_W-1:0]  win;
            logic              line_q;
            logic [DW-1:0]     ent_q;

            assign req = ((k == 0) ? fst_q : nst_q) & en_q;

            itl_pick #(.NUM_CH(NUM_CH)) u_pick (
                .req(req), .prio_flat(prio_flat), .hit(hit), .idx(win)
            );

            // Registered request line and entry address of this class.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_q <= 1'b1;
                    ent_q  <= '0;
                end else begin
                    line_q <= !hit;
                    ent_q  <= hit ? base_q + ((DW'(win) + DW'(1)) << 2) : base_q;
                end
            end
        end
    endgenerate

    assign fast_req_n = g_cls[0].line_q;
    assign norm_req_n = g_cls[1].line_q;
    assign fast_entry = g_cls[0].ent_q;
    assign norm_entry = g_cls[1].ent_q;
endmodule

// File: rtl/itl_chk.sv
// Module: property checker bound to irq_two_level_ctrl.
// Watches capture, stickiness, request lines and the empty-class entry.
// Assumes: rst_n is driven to a known level from time zero.
module itl_chk #(
    parameter int NUM_CH = 64,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] evt_in,
    input logic [NUM_CH-1:0] fast_cls,
    input logic [NUM_CH-1:0] fst,
    input logic [NUM_CH-1:0] nst,
    input logic [NUM_CH-1:0] en,
    input logic [DW-1:0]     base,
    input logic              fast_req_n,
    input logic              norm_req_n,
    input logic [DW-1:0]     fast_entry,
    input logic [DW-1:0]     norm_entry
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (fast_req_n && norm_req_n));
    // R2
    fast_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_in & fast_cls) & ~fst) == '0));
    // R3
    norm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_in & ~fast_cls) & ~nst) == '0));
    // R5
    fast_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fst & ~$past(fst) & ~$past(evt_in & fast_cls)) == '0));
    // R5
    norm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((nst & ~$past(nst) & ~$past(evt_in & ~fast_cls)) == '0));
    // R4
    fast_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fast_req_n == !$past(|(fst & en))));
    // R4
    norm_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (norm_req_n == !$past(|(nst & en))));
    // R7
    fast_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(fst & en)) |=> (fast_entry == $past(base)));
    // R7
    norm_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(nst & en)) |=> (norm_entry == $past(base)));
endmodule

bind irq_two_level_ctrl itl_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .fast_cls(fast_cls),
    .fst(fst_q), .nst(nst_q), .en(en_q), .base(base_q),
    .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
    .fast_entry(fast_entry), .norm_entry(norm_entry)
);

// File: tb/sim_irq_two_level_ctrl.sv
module sim_irq_two_level_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, fast_entry, norm_entry;
    logic        fast_req_n, norm_req_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_two_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fast_req_n(fast_req_n), .norm_req_n(norm_req_n),
        .fast_entry(fast_entry), .norm_entry(norm_entry)
    );

    typedef struct {
        string       tag;
        logic        f_n;
        logic        n_n;
        logic [31:0] f_ent;
        logic [31:0] n_ent;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state built from the requirements.
    logic [31:0] m_base = '0;
    logic [63:0] m_en = '0, m_fst = '0, m_nst = '0;
    logic [2:0]  m_prio [64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scan levels from most urgent, then channels ascending (R6, R7).
    function automatic logic [31:0] model_entry(input logic [63:0] req);
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 64; c++)
                if (req[c] && m_prio[c] == 3'(p)) return m_base + 32'((c + 1) * 4);
        return m_base;
    endfunction

    // Driver side: push the expected result once outputs have settled.
    task automatic expect_sb(input string tag);
        sb_item_t it;
        @(posedge clk);
        @(posedge clk);
        it.tag   = tag;
        it.f_n   = !(|(m_fst & m_en));
        it.n_n   = !(|(m_nst & m_en));
        it.f_ent = model_entry(m_fst & m_en);
        it.n_ent = model_entry(m_nst & m_en);
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor side: pop and compare away from the active edge.
    initial forever begin
        @(negedge clk);
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk({it.tag, " fast line"}, 32'(fast_req_n), 32'(it.f_n));
            chk({it.tag, " normal line"}, 32'(norm_req_n), 32'(it.n_n));
            chk({it.tag, " fast entry"}, fast_entry, it.f_ent);
            chk({it.tag, " normal entry"}, norm_entry, it.n_ent);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    function automatic logic [31:0] prio_word(input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++) v[4*k +: 3] = m_prio[w*8 + k];
        return v;
    endfunction

    task automatic set_prio(input int c, input logic [2:0] p);
        m_prio[c] = p;
        wr(5'(16 + c / 8), prio_word(c / 8));
    endtask

    task automatic pulse(input logic [63:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
        for (int c = 0; c < 64; c++)
            if (m[c]) begin
                if (m_prio[c] <= 3'd1) m_fst[c] = 1'b1;
                else                   m_nst[c] = 1'b1;
            end
    endtask

    initial begin
        for (int c = 0; c < 64; c++) m_prio[c] = 3'd7;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 fast line", 32'(fast_req_n), 32'd1);
        chk("R1 normal line", 32'(norm_req_n), 32'd1);
        chk("R1 fast entry", fast_entry, 32'd0);
        chk("R1 normal entry", norm_entry, 32'd0);
        for (int w = 1; w <= 6; w++) rd_chk("R1 status/enable word", 5'(w), 32'd0);
        rd_chk("R1 R9 priority reset", 5'd16, 32'h7777_7777);

        // R9 base and priority layout
        wr(5'd0, 32'h0000_1000); m_base = 32'h0000_1000;
        rd_chk("R9 base readback", 5'd0, 32'h0000_1000);
        set_prio(5, 3'd1);
        set_prio(9, 3'd3);
        rd_chk("R9 priority word 16", 5'd16, 32'h7717_7777);
        rd_chk("R9 priority word 17", 5'd17, 32'h7777_7737);

        // R2 R3 capture while masked
        pulse((64'd1 << 5) | (64'd1 << 9));
        rd_chk("R2 R3 fast status word", 5'd1, 32'h0000_0020);
        rd_chk("R2 normal status word", 5'd3, 32'h0000_0200);
        rd_chk("R2 fast status high word", 5'd2, 32'd0);
        expect_sb("R3 masked");

        // R8 timing and R4 enable
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd5; reg_wdata = (32'd1 << 5) | (32'd1 << 9);
        @(negedge clk);
        reg_wr = 1'b0;
        m_en = (64'd1 << 5) | (64'd1 << 9);
        chk("R8 fast line one edge later", 32'(fast_req_n), 32'd1);
        chk("R8 normal entry one edge later", norm_entry, 32'h0000_1000);
        @(negedge clk);
        chk("R4 fast line", 32'(fast_req_n), 32'd0);
        chk("R4 normal line", 32'(norm_req_n), 32'd0);
        chk("R7 R8 fast entry", fast_entry, 32'h0000_1018);
        chk("R7 R8 normal entry", norm_entry, 32'h0000_1028);
        rd_chk("R7 fast entry word", 5'd7, 32'h0000_1018);
        rd_chk("R7 normal entry word", 5'd8, 32'h0000_1028);

        // R6 lower priority value wins
        set_prio(40, 3'd2);
        wr(5'd6, 32'd1 << 8); m_en[40] = 1'b1;
        pulse(64'd1 << 40);
        expect_sb("R6 lower level wins");

        // R6 tie goes to lower channel
        set_prio(2, 3'd2);
        wr(5'd5, (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9)); m_en[2] = 1'b1;
        pulse(64'd1 << 2);
        expect_sb("R6 tie");

        // R5 write-one-to-clear
        wr(5'd3, 32'd1 << 2); m_nst[2] = 1'b0;
        expect_sb("R5 clear");
        rd_chk("R5 normal status after clear", 5'd3, 32'h0000_0200);
        rd_chk("R5 normal status high", 5'd4, 32'h0000_0100);

        // R5 clear while input held keeps the bit
        @(negedge clk);
        evt_in = 64'd1 << 5;
        wr(5'd1, 32'd1 << 5);
        @(negedge clk);
        evt_in = '0;
        rd_chk("R5 held input keeps bit", 5'd1, 32'h0000_0020);
        wr(5'd1, 32'd0);
        rd_chk("R5 zero write no effect", 5'd1, 32'h0000_0020);

        // R6 R8 re-prioritisation moves the normal winner
        set_prio(9, 3'd2);
        expect_sb("R6 R8 priority change");

        // R2 R6 fast class ordering
        set_prio(12, 3'd0);
        wr(5'd5, (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 12));
        m_en[12] = 1'b1;
        pulse(64'd1 << 12);
        expect_sb("R2 R6 fast winner");

        // R4 masking the fast winner falls back
        wr(5'd5, (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9)); m_en[12] = 1'b0;
        expect_sb("R4 mask winner");

        // R7 all cleared presents base
        wr(5'd1, 32'hFFFF_FFFF); wr(5'd2, 32'hFFFF_FFFF);
        wr(5'd3, 32'hFFFF_FFFF); wr(5'd4, 32'hFFFF_FFFF);
        m_fst = '0; m_nst = '0;
        expect_sb("R7 empty");
        rd_chk("R7 fast entry empty", 5'd7, 32'h0000_1000);
        rd_chk("R7 normal entry empty", 5'd8, 32'h0000_1000);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule